// File: doc/BRIEF.md
# Add/Subtract Unit with Condition Flags

This block is a combinational two's-complement arithmetic unit of configurable width. A single select input chooses between the sum and the difference of two operands. The difference is formed by feeding the bitwise inverse of the second operand into the same ripple adder and setting the adder's carry-in to one. Along with the arithmetic result, the block produces four condition flags:

- zero
- negative
- carry out of the top bit
- signed overflow

A relation decoder reads only those four flags and returns one bit for a selected comparison. When the unit subtracts, that bit answers an equality, signed or unsigned question about the two operands.

Typical use is as the arithmetic half of a datapath. The same operand pair serves both plain add/subtract instructions and compare-and-branch decisions. There are no registers, so the result, the flags and the relation bit are valid in the same cycle as the inputs.

Top module: `addsub_flags_unit`

## Requirements
- R1: With `sub_sel`=0, `result` equals (`op_a` + `op_b`) modulo 2^WIDTH.
- R2: With `sub_sel`=1, `result` equals (`op_a` − `op_b`) modulo 2^WIDTH. It is formed as `op_a` + ~`op_b` + 1, with the +1 entering as the carry-in of bit 0.
- R3: `flag_c` is the carry out of the most significant bit. For an add it is 1 exactly when `op_a`+`op_b` ≥ 2^WIDTH. For a subtract it is 1 exactly when `op_a` ≥ `op_b` as unsigned numbers.
- R4: `flag_z` is 1 exactly when every bit of `result` is 0.
- R5: `flag_n` equals bit WIDTH−1 of `result`.
- R6: `flag_v` is 1 exactly when `op_a` and the adder's second operand (`op_b`, or ~`op_b` when subtracting) have the same top bit and the top bit of `result` differs from it. This is the case where the true signed sum or difference lies outside −2^(WIDTH−1) … 2^(WIDTH−1)−1.
- R7: Relation code 0 (equal) returns `flag_z`, and code 1 (not equal) returns not `flag_z`.
- R8: The signed relation codes are decoded with L = `flag_n` xor `flag_v`:

  | Code | Relation | Returns |
  |------|----------|---------|
  | 2 | less | L |
  | 3 | less-or-equal | L or `flag_z` |
  | 4 | greater-or-equal | not L |
  | 5 | greater | not (L or `flag_z`) |

- R9: The unsigned relation codes are decoded as follows:

  | Code | Relation | Returns |
  |------|----------|---------|
  | 6 | below | not `flag_c` |
  | 7 | below-or-same | (not `flag_c`) or `flag_z` |
  | 8 | above-or-same | `flag_c` |
  | 9 | above | `flag_c` and not `flag_z` |

- R10: Relation codes 10 to 15 return 0 whatever the operands are.
- R11: With `sub_sel`=1, `rel_out` equals the true comparison of `op_a` against `op_b` for all ten codes. Codes 2–5 use signed interpretation and codes 6–9 use unsigned interpretation.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | WIDTH | First operand |
| op_b | input | WIDTH | Second operand |
| sub_sel | input | 1 | 1 selects subtract, 0 selects add |
| rel_sel | input | 4 | Relation code, see R7–R10 |
| result | output | WIDTH | Sum or difference |
| flag_z | output | 1 | Result is zero |
| flag_n | output | 1 | Result sign bit |
| flag_c | output | 1 | Carry out of top bit |
| flag_v | output | 1 | Signed overflow |
| rel_out | output | 1 | Selected relation bit |

## Verification
The in-line checks assume the operands and select inputs carry known two-state values. They also assume the relation bit is compared with a true ordering of the operands only while `sub_sel` is high, since an add leaves flags that do not describe `op_a` against `op_b`. The stimulus drives only defined values and checks the relation bit in add mode only against its flag-based decoding. It sweeps every operand pair, both operations and all sixteen relation codes on a four-bit instance. This covers 0+1, −1+1, the most negative value minus one and the most positive value plus one.

// File: rtl/addsub_pkg.sv
package addsub_pkg;

    localparam int REL_BITS = 4;

    typedef enum logic [REL_BITS-1:0] {
        REL_EQ  = 4'd0,
        REL_NE  = 4'd1,
        REL_LT  = 4'd2,
        REL_LE  = 4'd3,
        REL_GE  = 4'd4,
        REL_GT  = 4'd5,
        REL_LTU = 4'd6,
        REL_LEU = 4'd7,
        REL_GEU = 4'd8,
        REL_GTU = 4'd9
    } rel_code_e;

    typedef struct packed {
        logic z;
        logic n;
        logic c;
        logic v;
    } cond_flags_t;

endpackage

// File: rtl/addsub_operand_cond.sv
module addsub_operand_cond #(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] b_in,
    input  logic             invert,
    output logic [WIDTH-1:0] b_out,
    output logic             carry_in
);

    // Per-bit conditional inversion; the +1 of negation becomes the carry-in.
    for (genvar i = 0; i < WIDTH; i++) begin : g_inv
        assign b_out[i] = b_in[i] ^ invert;
    end
    assign carry_in = invert;

    always_comb begin
        if (invert) begin
            AST_INVERTED_OPERAND: assert (b_out == ~b_in); // R2
        end else begin
            AST_PASSED_OPERAND: assert (b_out == b_in); // R1
        end
    end

endmodule

// File: rtl/addsub_ripple.sv
module addsub_ripple #(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    input  logic             cin,
    output logic [WIDTH-1:0] sum,
    output logic             cout
);

    localparam int EXT = WIDTH + 1;

    logic [WIDTH:0] carry;

    assign carry[0] = cin;

    for (genvar i = 0; i < WIDTH; i++) begin : g_fa
        logic half;
        assign half         = a[i] ^ b[i];
        assign sum[i]       = half ^ carry[i];
        assign carry[i + 1] = (a[i] & b[i]) | (half & carry[i]);
    end

    assign cout = carry[WIDTH];

    always_comb begin
        AST_RIPPLE_SUM: assert ({cout, sum} ==
            (EXT'({1'b0, a}) + EXT'({1'b0, b}) + EXT'({{WIDTH{1'b0}}, cin}))); // R1
    end

endmodule

// File: rtl/addsub_flag_gen.sv
module addsub_flag_gen
    import addsub_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] sum,
    input  logic             carry_out,
    input  logic             a_sign,
    input  logic             b_sign,
    output cond_flags_t      flags
);

    localparam int MSB = WIDTH - 1;

    always_comb begin
        flags.z = ~|sum;
        flags.n = sum[MSB];
        flags.c = carry_out;
        flags.v = (a_sign == b_sign) && (sum[MSB] != a_sign);
    end

    always_comb begin
        if (flags.v) begin
            AST_OVF_SIGNS: assert (flags.n != a_sign); // R6
        end
        if (flags.z) begin
            AST_ZERO_NOT_NEG: assert (!flags.n); // R4
        end
    end

endmodule

// File: rtl/addsub_rel_decode.sv
module addsub_rel_decode
    import addsub_pkg::*;
(
    input  cond_flags_t          flags,
    input  logic [REL_BITS-1:0]  code,
    output logic                 hit
);

    logic lt_s;
    logic le_u;

    assign lt_s = flags.n ^ flags.v;
    assign le_u = ~flags.c | flags.z;

    always_comb begin
        unique case (code)
            REL_EQ:  hit = flags.z;
            REL_NE:  hit = ~flags.z;
            REL_LT:  hit = lt_s;
            REL_LE:  hit = flags.z | lt_s;
            REL_GE:  hit = ~lt_s;
            REL_GT:  hit = ~(flags.z | lt_s);
            REL_LTU: hit = ~flags.c;
            REL_LEU: hit = le_u;
            REL_GEU: hit = flags.c;
            REL_GTU: hit = ~le_u;
            default: hit = 1'b0;
        endcase
    end

    always_comb begin
        if (code > REL_GTU) begin
            AST_UNUSED_CODE_LOW: assert (!hit); // R10
        end
    end

endmodule

// File: rtl/addsub_flags_unit.sv
module addsub_flags_unit
    import addsub_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0]    op_a,
    input  logic [WIDTH-1:0]    op_b,
    input  logic                sub_sel,
    input  logic [3:0]          rel_sel,
    output logic [WIDTH-1:0]    result,
    output logic                flag_z,
    output logic                flag_n,
    output logic                flag_c,
    output logic                flag_v,
    output logic                rel_out
);

    localparam int MSB = WIDTH - 1;

    logic [WIDTH-1:0] b_eff;
    logic             cin;
    logic             cout;
    cond_flags_t      flags;

    addsub_operand_cond #(.WIDTH(WIDTH)) u_cond (
        .b_in     (op_b),
        .invert   (sub_sel),
        .b_out    (b_eff),
        .carry_in (cin)
    );

    addsub_ripple #(.WIDTH(WIDTH)) u_adder (
        .a    (op_a),
        .b    (b_eff),
        .cin  (cin),
        .sum  (result),
        .cout (cout)
    );

    addsub_flag_gen #(.WIDTH(WIDTH)) u_flags (
        .sum       (result),
        .carry_out (cout),
        .a_sign    (op_a[MSB]),
        .b_sign    (b_eff[MSB]),
        .flags     (flags)
    );

    addsub_rel_decode u_rel (
        .flags (flags),
        .code  (rel_sel),
        .hit   (rel_out)
    );

    assign flag_z = flags.z;
    assign flag_n = flags.n;
    assign flag_c = flags.c;
    assign flag_v = flags.v;

    always_comb begin
        if (sub_sel) begin
            AST_SUB_RESULT: assert (result == op_a - op_b); // R2
            AST_SUB_CARRY: assert (flag_c == (op_a >= op_b)); // R3
            if (rel_sel == REL_EQ) begin
                AST_SUB_EQ: assert (rel_out == (op_a == op_b)); // R11
            end
            if (rel_sel == REL_LT) begin
                AST_SUB_LT: assert (rel_out == ($signed(op_a) < $signed(op_b))); // R11
            end
            if (rel_sel == REL_LTU) begin
                AST_SUB_LTU: assert (rel_out == (op_a < op_b)); // R11
            end
        end else begin
            AST_ADD_RESULT: assert (result == op_a + op_b); // R1
        end
        if (rel_sel > REL_GTU) begin
            AST_UNUSED_CODE: assert (!rel_out); // R10
        end
    end

endmodule

// File: tb/addsub_flags_unit_bench.sv
module addsub_flags_unit_bench;

    localparam int CLK_PERIOD = 10;
    localparam int W          = 4;
    localparam int SPAN       = 1 << W;
    localparam int HALF       = 1 << (W - 1);
    localparam int MASK       = SPAN - 1;

    logic         clk = 1'b0;
    logic [W-1:0] op_a = '0;
    logic [W-1:0] op_b = '0;
    logic         sub_sel = 1'b0;
    logic [3:0]   rel_sel = 4'd0;
    logic [W-1:0] result;
    logic         flag_z, flag_n, flag_c, flag_v, rel_out;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    addsub_flags_unit #(.WIDTH(W)) u_addsub_flags_unit (
        .op_a    (op_a),
        .op_b    (op_b),
        .sub_sel (sub_sel),
        .rel_sel (rel_sel),
        .result  (result),
        .flag_z  (flag_z),
        .flag_n  (flag_n),
        .flag_c  (flag_c),
        .flag_v  (flag_v),
        .rel_out (rel_out)
    );

    task automatic check(input int act, input int exp, input string tag, input string what);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual=%0d expected=%0d (a=%0d b=%0d sub=%0d code=%0d)",
                     tag, what, act, exp, op_a, op_b, sub_sel, rel_sel);
        end
    endtask

    function automatic int to_signed(input int u);
        return (u >= HALF) ? u - SPAN : u;
    endfunction

    // Relation decoding from flags, per R7, R8, R9, R10
    function automatic int rel_from_flags(input int code, input int z, input int n,
                                          input int c, input int v);
        int l;
        l = n ^ v;
        case (code)
            0: return z;
            1: return 1 - z;
            2: return l;
            3: return l | z;
            4: return 1 - l;
            5: return 1 - (l | z);
            6: return 1 - c;
            7: return (1 - c) | z;
            8: return c;
            9: return c & (1 - z);
            default: return 0;
        endcase
    endfunction

    // True operand ordering, per R11
    function automatic int rel_true(input int code, input int ua, input int ub);
        int sa, sb;
        sa = to_signed(ua);
        sb = to_signed(ub);
        case (code)
            0: return int'(ua == ub);
            1: return int'(ua != ub);
            2: return int'(sa < sb);
            3: return int'(sa <= sb);
            4: return int'(sa >= sb);
            5: return int'(sa > sb);
            6: return int'(ua < ub);
            7: return int'(ua <= ub);
            8: return int'(ua >= ub);
            9: return int'(ua > ub);
            default: return 0;
        endcase
    endfunction

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        // Idle state: zero operands, add, equal code
        check(int'(result), 0, "R1", "idle result");
        check(int'(flag_z), 1, "R4", "idle zero");
        check(int'(rel_out), 1, "R7", "idle equal");

        for (int s = 0; s < 2; s++) begin
            for (int ua = 0; ua < SPAN; ua++) begin
                for (int ub = 0; ub < SPAN; ub++) begin
                    for (int code = 0; code < 16; code++) begin
                        int exp_res, exp_c, exp_z, exp_n, exp_v, true_val;
                        string rtag;
                        sub_sel = s[0];
                        op_a    = ua[W-1:0];
                        op_b    = ub[W-1:0];
                        rel_sel = code[3:0];
                        @(negedge clk);
                        if (s == 1) begin
                            true_val = to_signed(ua) - to_signed(ub);
                            exp_res  = (ua - ub + SPAN) & MASK;
                            exp_c    = int'(ua >= ub);
                        end else begin
                            true_val = to_signed(ua) + to_signed(ub);
                            exp_res  = (ua + ub) & MASK;
                            exp_c    = int'(ua + ub >= SPAN);
                        end
                        exp_z = int'(exp_res == 0);
                        exp_n = (exp_res >> (W - 1)) & 1;
                        exp_v = int'(true_val < -HALF || true_val > HALF - 1);
                        if (code == 0) begin
                            check(int'(result), exp_res, (s == 1) ? "R2" : "R1", "result");
                            check(int'(flag_c), exp_c, "R3", "carry");
                            check(int'(flag_z), exp_z, "R4", "zero");
                            check(int'(flag_n), exp_n, "R5", "negative");
                            check(int'(flag_v), exp_v, "R6", "overflow");
                        end
                        if (code < 2)       rtag = "R7";
                        else if (code < 6)  rtag = "R8";
                        else if (code < 10) rtag = "R9";
                        else                rtag = "R10";
                        check(int'(rel_out), rel_from_flags(code, exp_z, exp_n, exp_c, exp_v),
                              rtag, "relation from flags");
                        if (s == 1 && code < 10) begin
                            check(int'(rel_out), rel_true(code, ua, ub), "R11", "true relation");
                        end
                    end
                end
            end
        end

        // Named corners: 0+1, -1+1, most negative - 1, most positive + 1
        sub_sel = 1'b0; op_a = '0; op_b = W'(1); rel_sel = 4'd0;
        @(negedge clk);
        check(int'(result), 1, "R1", "0+1 result");
        check(int'(flag_c), 0, "R3", "0+1 carry");
        op_a = '1;
        @(negedge clk);
        check(int'(result), 0, "R1", "-1+1 result");
        check(int'(flag_c), 1, "R3", "-1+1 carry");
        check(int'(flag_v), 0, "R6", "-1+1 overflow");
        sub_sel = 1'b1; op_a = W'(HALF); op_b = W'(1);
        @(negedge clk);
        check(int'(result), HALF - 1, "R2", "min-1 result");
        check(int'(flag_v), 1, "R6", "min-1 overflow");
        sub_sel = 1'b0; op_a = W'(HALF - 1); op_b = W'(1);
        @(negedge clk);
        check(int'(result), HALF, "R1", "max+1 result");
        check(int'(flag_v), 1, "R6", "max+1 overflow");
        check(int'(flag_n), 1, "R5", "max+1 negative");

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule